// File: doc/BRIEF.md
# Routed Interrupt Level Controller

The block gathers 32 hardware interrupt sources into one system-level pending word. It then steers them, as priority levels, to the processors of a small cluster. Each source position has a fixed level from 0 to 15, taken from a parameter table set at elaboration. Every source that is pending and not masked raises the bit for its level in the level vector of one processor, which software chooses. A 16-bit soft-level input per processor comes from that processor's own slice and is ORed into that processor's vector.

Software reaches the block through a small word-indexed register port. One index reads the pending word and one reads the mask word. Two indices change the mask: one clears mask bits and one sets them, writing a one in each bit to change. One index holds the target processor. A single high bit of the mask word blocks all routed hardware levels at once. A per-processor timer input sets a shared pending bit and also drives that processor's timer level directly. The output vectors are registered. A per-bit change strobe marks every raise and every lower, for consumers that act on edges.

Top module: `irq_router`

## Requirements
- R1: After reset the pending word is zero, the target is zero, and every level and change output is zero. The mask word holds 0x0FA2007F, so index 1 reads as zero.
- R2: Index 0 reads the pending word with bit 31 forced to 0, and index 4 reads the target zero-extended. Indices 5 to 7 read zero. Writes to indices 0, 1 and 5 to 7 change nothing.
- R3: A write to index 2 clears each mask bit where the data has a one and the implemented mask 0xF05DFF80 has a one. Index 1 reads the mask word ANDed with that same implemented mask.
- R4: A write to index 3 sets the written implemented bits in the mask word and clears those same bits in the pending word. The clear takes priority over a source edge in the same cycle.
- R5: A write to index 4 stores the data ANDed with NCPU-1. Only that processor's vector carries routed hardware levels.
- R6: A rising source input sets its pending bit and a falling one clears it. Both are seen on index 0 one edge after the change and on the level outputs two edges after it. A source whose table level is 0 never sets its pending bit.
- R7: Each pending source that is not masked sets bit table[j] of the target's vector. Sources that share a level hold it while any one of them is active. The default table includes source 7 to level 2, source 9 to 5, source 29 to 5, source 19 to 14, and sources 3 and 17 to level 0.
- R8: Mask bit 31 removes all routed hardware levels from every vector. It does not affect soft levels.
- R9: Each processor's soft-level input is ORed into that processor's own vector one edge later. Soft bit 0 is ignored, and level bit 0 of every output is always 0.
- R10: While timer input c is high, processor c's vector carries level table[TIMER_BIT] (14 by default) one edge later. A rising edge on any timer input sets pending bit TIMER_BIT (19 by default), and a falling edge clears it.
- R11: The level outputs are registered. Each change bit is high for exactly the one cycle in which its level bit differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Hardware source levels |
| timer_in | input | NCPU | Per-processor timer levels |
| soft_lvl | input | NCPU*16 | Soft levels from each processor's slice, 16 bits per processor |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx (combinational) |
| lvl_out | output | NCPU*16 | Registered level vector per processor |
| lvl_chg | output | NCPU*16 | One-cycle change strobe per level bit |

## Verification
The properties assume a register index that is held stable around each clock edge. They also assume that source pending bits change only through edges seen by the block, never through a forced value. The global-mask property relates the output to the previous cycle's mask, soft and timer inputs. It assumes that soft and timer inputs are quiet whenever they are meant to show suppression. The stimulus drives every input only at falling clock edges and changes one source or register at a time. It waits for the stated one-edge or two-edge latency before it expects a result.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 32;
  localparam int NLVL = 16;
  localparam logic [NSRC-1:0] IMPL_MASK = 32'hF05D_FF80;
  localparam logic [NSRC-1:0] DIS_RST   = 32'h0FA2_007F;
  localparam int GDIS_BIT = 31;

  typedef logic [3:0]      lvl_idx_t;
  typedef logic [NLVL-1:0] lvl_vec_t;
  typedef lvl_idx_t        lvl_map_t [NSRC];

  typedef enum logic [2:0] {
    RI_PEND  = 3'd0,
    RI_MASK  = 3'd1,
    RI_UNMSK = 3'd2,
    RI_SETMS = 3'd3,
    RI_TGT   = 3'd4
  } reg_idx_e;

  localparam lvl_map_t DEF_MAP = '{
    4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd2,
    4'd3, 4'd5, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11, 4'd13,
    4'd1, 4'd0, 4'd4, 4'd14, 4'd8, 4'd0, 4'd12, 4'd0,
    4'd0, 4'd0, 4'd0, 4'd0, 4'd15, 4'd5, 4'd3, 4'd0
  };

  // one-hot level bit; level 0 never drives anything
  function automatic lvl_vec_t lvl_bit(input lvl_idx_t l);
    lvl_vec_t v;
    v = '0;
    if (l != 4'd0) v[l] = 1'b1;
    return v;
  endfunction

  // sources whose table entry is non-zero
  function automatic logic [NSRC-1:0] live_srcs(input lvl_map_t m);
    logic [NSRC-1:0] s;
    for (int j = 0; j < NSRC; j++) s[j] = (m[j] != 4'd0);
    return s;
  endfunction

  // fold an active-source word down to a level vector
  function automatic lvl_vec_t fold_levels(input logic [NSRC-1:0] act, input lvl_map_t m);
    lvl_vec_t v;
    v = '0;
    for (int j = 0; j < NSRC; j++)
      if (act[j]) v = v | lvl_bit(m[j]);
    return v;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int TW = 2,
  parameter int TIMER_BIT = 19,
  parameter lvl_map_t LVL_MAP = DEF_MAP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NCPU-1:0] timer_in,
  input  logic            reg_wr,
  input  logic [2:0]      reg_idx,
  input  logic [31:0]     reg_wdata,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] dis_q,
  output logic [TW-1:0]   tgt_q,
  output logic [31:0]     reg_rdata
);
  localparam logic [NSRC-1:0] LIVE = live_srcs(LVL_MAP);

  logic [NSRC-1:0] src_q;
  logic [NCPU-1:0] tmr_q;
  logic [NSRC-1:0] src_rise, src_fall, wmask, pend_d;
  logic            tmr_rise, tmr_fall;
  logic            wr_unmask, wr_setmask, wr_tgt;

  assign src_rise   = src_in & ~src_q & LIVE;
  assign src_fall   = ~src_in & src_q & LIVE;
  assign tmr_rise   = |(timer_in & ~tmr_q);
  assign tmr_fall   = |(~timer_in & tmr_q);
  assign wmask      = reg_wdata & IMPL_MASK;
  assign wr_unmask  = reg_wr && (reg_idx == RI_UNMSK);
  assign wr_setmask = reg_wr && (reg_idx == RI_SETMS);
  assign wr_tgt     = reg_wr && (reg_idx == RI_TGT);

  always_comb begin
    pend_d = (pend_q | src_rise) & ~src_fall;
    if (tmr_rise)      pend_d[TIMER_BIT] = 1'b1;
    else if (tmr_fall) pend_d[TIMER_BIT] = 1'b0;
    if (wr_setmask)    pend_d = pend_d & ~wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      tmr_q  <= '0;
      pend_q <= '0;
      dis_q  <= DIS_RST;
      tgt_q  <= '0;
    end else begin
      src_q  <= src_in;
      tmr_q  <= timer_in;
      pend_q <= pend_d;
      if (wr_unmask)  dis_q <= dis_q & ~wmask;
      if (wr_setmask) dis_q <= dis_q | wmask;
      if (wr_tgt)     tgt_q <= reg_wdata[TW-1:0];
    end
  end

  always_comb begin
    case (reg_idx)
      RI_PEND: reg_rdata = {1'b0, pend_q[NSRC-2:0]};
      RI_MASK: reg_rdata = dis_q & IMPL_MASK;
      RI_TGT:  reg_rdata = 32'(tgt_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int TW = 2,
  parameter int TIMER_BIT = 19,
  parameter lvl_map_t LVL_MAP = DEF_MAP
) (
  input  logic [NSRC-1:0]      pend,
  input  logic [NSRC-1:0]      dis,
  input  logic [TW-1:0]        tgt,
  input  logic [NCPU*NLVL-1:0] soft_lvl,
  input  logic [NCPU-1:0]      timer_in,
  output lvl_vec_t             hw_lvl,
  output logic [NCPU*NLVL-1:0] lvl_next
);
  localparam lvl_vec_t TMR_LVL  = lvl_bit(LVL_MAP[TIMER_BIT]);
  localparam lvl_vec_t SOFT_USE = {{(NLVL-1){1'b1}}, 1'b0};

  assign hw_lvl = dis[GDIS_BIT] ? '0 : fold_levels(pend & ~dis, LVL_MAP);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic sel;
    assign sel = (tgt == TW'(c));
    assign lvl_next[c*NLVL +: NLVL] = (sel ? hw_lvl : '0)
                                    | (soft_lvl[c*NLVL +: NLVL] & SOFT_USE)
                                    | (timer_in[c] ? TMR_LVL : '0);
  end
endmodule

// File: rtl/irq_outreg.sv
module irq_outreg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] chg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      chg <= '0;
    end else begin
      q   <= d;
      chg <= d ^ q;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int TIMER_BIT = 19,
  parameter lvl_map_t LVL_MAP = DEF_MAP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_in,
  input  logic [NCPU-1:0]      timer_in,
  input  logic [NCPU*NLVL-1:0] soft_lvl,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_idx,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NCPU*NLVL-1:0] lvl_out,
  output logic [NCPU*NLVL-1:0] lvl_chg
);
  localparam int TW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int OW = NCPU * NLVL;

  logic [NSRC-1:0] pend_word, dis_word;
  logic [TW-1:0]   tgt_sel;
  lvl_vec_t        hw_lvl;
  logic [OW-1:0]   lvl_next;

  irq_regs #(.NCPU(NCPU), .TW(TW), .TIMER_BIT(TIMER_BIT), .LVL_MAP(LVL_MAP)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .timer_in(timer_in),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .pend_q(pend_word), .dis_q(dis_word), .tgt_q(tgt_sel), .reg_rdata(reg_rdata)
  );

  irq_route #(.NCPU(NCPU), .TW(TW), .TIMER_BIT(TIMER_BIT), .LVL_MAP(LVL_MAP)) u_route (
    .pend(pend_word), .dis(dis_word), .tgt(tgt_sel), .soft_lvl(soft_lvl),
    .timer_in(timer_in), .hw_lvl(hw_lvl), .lvl_next(lvl_next)
  );

  irq_outreg #(.W(OW)) u_out (
    .clk(clk), .rst_n(rst_n), .d(lvl_next), .q(lvl_out), .chg(lvl_chg)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int TW = 2,
  parameter int TIMER_BIT = 19,
  parameter lvl_map_t LVL_MAP = DEF_MAP
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [2:0]           reg_idx,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic [NCPU*NLVL-1:0] soft_lvl,
  input logic [NCPU-1:0]      timer_in,
  input logic [NCPU*NLVL-1:0] lvl_out,
  input logic [NCPU*NLVL-1:0] lvl_chg,
  input logic [NSRC-1:0]      pend_word,
  input logic [TW-1:0]        tgt_sel
);
  logic [NSRC-1:0] zero_lvl;
  logic            any_bit0;

  always_comb begin
    for (int j = 0; j < NSRC; j++) zero_lvl[j] = (LVL_MAP[j] == 4'd0) && (j != TIMER_BIT);
    any_bit0 = 1'b0;
    for (int c = 0; c < NCPU; c++) any_bit0 = any_bit0 | lvl_out[c*NLVL];
  end

  // R2
  pend_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 3'd0) |-> (reg_rdata[31] == 1'b0));

  // R2
  unused_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx > 3'd4) |-> (reg_rdata == 32'd0));

  // R4
  setmask_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 3'd3) |=> ((pend_word & $past(reg_wdata & IMPL_MASK)) == '0));

  // R5
  target_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 3'd4) |=> (tgt_sel == $past(reg_wdata[TW-1:0])));

  // R6
  zero_level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_word & zero_lvl) == '0));

  // R8
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 3'd1 && reg_rdata[31] && soft_lvl == '0 && timer_in == '0) |=> (lvl_out == '0));

  // R9
  level_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_bit0 == 1'b0));

  // R11
  change_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_chg == (lvl_out ^ $past(lvl_out))));
endmodule

bind irq_router irq_router_chk #(
  .NCPU(NCPU), .TW(TW), .TIMER_BIT(TIMER_BIT), .LVL_MAP(LVL_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .soft_lvl(soft_lvl),
  .timer_in(timer_in), .lvl_out(lvl_out), .lvl_chg(lvl_chg),
  .pend_word(pend_word), .tgt_sel(tgt_sel)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;
  localparam int NCPU = 4;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [31:0]         src_in;
  logic [NCPU-1:0]     timer_in;
  logic [NCPU*16-1:0]  soft_lvl;
  logic                reg_wr;
  logic [2:0]          reg_idx;
  logic [31:0]         reg_wdata;
  logic [31:0]         reg_rdata;
  logic [NCPU*16-1:0]  lvl_out;
  logic [NCPU*16-1:0]  lvl_chg;

  always #5 clk = ~clk;

  irq_router #(.NCPU(NCPU)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .timer_in(timer_in),
    .soft_lvl(soft_lvl), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lvl_out(lvl_out),
    .lvl_chg(lvl_chg)
  );

  typedef struct {
    string       req;
    int          kind;   // 0 read data, 1 level vector, 2 change strobe
    int          idx;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  function automatic void push(string req, int kind, int idx, logic [31:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.idx = idx; it.exp = exp;
    q.push_back(it);
  endfunction

  // scoreboard monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = reg_rdata;
          1:       act = 32'(lvl_out[it.idx*16 +: 16]);
          default: act = 32'(lvl_chg[it.idx*16 +: 16]);
        endcase
        checks++;
        if (act !== it.exp) begin
          errs++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.req, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] idx, logic [31:0] data);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = data;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [2:0] idx, logic [31:0] exp);
    reg_idx = idx;
    push(req, 0, 0, exp);
    step(1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_in = '0; timer_in = '0; soft_lvl = '0;
    reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0;
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    for (int c = 0; c < NCPU; c++) push("R1", 1, c, 0);
    push("R1", 2, 0, 0);
    rd("R1", 0, 32'h0);
    rd("R1", 1, 32'h0);
    rd("R1", 4, 32'h0);

    // R6 latency, R7 routing, R11 strobe
    src_in[7] = 1'b1;
    push("R6", 1, 0, 0);
    step(1);
    push("R7", 1, 0, 32'h0004);
    push("R11", 2, 0, 32'h0004);
    push("R5", 1, 1, 0);
    step(1);
    push("R11", 2, 0, 0);
    rd("R6", 0, 32'h0000_0080);

    // R7 shared levels
    src_in[9] = 1'b1; src_in[29] = 1'b1;
    step(3);
    push("R7", 1, 0, 32'h0024);
    rd("R6", 0, 32'h2000_0280);
    src_in[9] = 1'b0;
    step(3);
    push("R7", 1, 0, 32'h0024);
    rd("R6", 0, 32'h2000_0080);

    // R6 level-zero sources ignored
    src_in[3] = 1'b1; src_in[17] = 1'b1;
    step(3);
    rd("R6", 0, 32'h2000_0080);
    push("R7", 1, 0, 32'h0024);
    step(1);

    // R4 set-mask clears pending
    wr(3'd3, 32'h0000_0080);
    push("R4", 1, 0, 32'h0020);
    step(1);
    rd("R4", 1, 32'h0000_0080);
    rd("R4", 0, 32'h2000_0000);

    // R3 unmask without a new edge leaves level off
    wr(3'd2, 32'h0000_0080);
    step(2);
    push("R3", 1, 0, 32'h0020);
    rd("R3", 1, 32'h0);
    src_in[7] = 1'b0; step(2);
    src_in[7] = 1'b1; step(3);
    push("R3", 1, 0, 32'h0024);
    rd("R6", 0, 32'h2000_0080);

    // R3/R4 unimplemented bits masked
    wr(3'd3, 32'h0000_007F);
    step(2);
    rd("R3", 1, 32'h0);
    rd("R4", 0, 32'h2000_0080);

    // R2 writes to other indices are ignored
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    step(2);
    rd("R2", 0, 32'h2000_0080);
    rd("R2", 1, 32'h0);
    rd("R2", 5, 32'h0);
    rd("R2", 7, 32'h0);
    rd("R2", 4, 32'h0);
    push("R2", 1, 0, 32'h0024);
    step(1);

    // R5 target selection, 6 & 3 = 2
    wr(3'd4, 32'h0000_0006);
    push("R5", 1, 2, 32'h0024);
    push("R5", 1, 0, 32'h0);
    push("R11", 2, 0, 32'h0024);
    push("R11", 2, 2, 32'h0024);
    step(1);
    rd("R5", 4, 32'h2);

    // R8 global mask, R9 soft levels
    wr(3'd3, 32'h8000_0000);
    push("R8", 1, 2, 32'h0);
    step(1);
    soft_lvl[2*16 +: 16] = 16'h0301;
    push("R9", 1, 2, 32'h0300);
    step(1);
    soft_lvl[1*16 +: 16] = 16'h8000;
    push("R9", 1, 1, 32'h8000);
    step(1);
    rd("R8", 1, 32'h8000_0000);
    rd("R2", 0, 32'h2000_0080);
    soft_lvl = '0;
    wr(3'd2, 32'h8000_0000);
    step(2);
    push("R8", 1, 2, 32'h0024);
    push("R9", 1, 1, 32'h0);
    step(1);

    // R10 timer: local level and shared pending bit
    timer_in[1] = 1'b1;
    push("R10", 1, 1, 32'h4000);
    step(1);
    push("R10", 1, 2, 32'h4024);
    step(1);
    rd("R10", 0, 32'h2008_0080);
    timer_in[1] = 1'b0;
    push("R10", 1, 1, 32'h0);
    step(1);
    push("R10", 1, 2, 32'h0024);
    step(1);
    rd("R10", 0, 32'h2000_0080);

    // R1 reset again mid-run
    rst_n = 1'b0;
    push("R1", 1, 2, 32'h0);
    push("R1", 2, 2, 32'h0);
    step(1);
    rd("R1", 4, 32'h0);
    rd("R1", 1, 32'h0);
    src_in = '0;
    rst_n = 1'b1;
    step(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule